// File: doc/BRIEF.md
# Descriptor Ring Index Registers

This block holds the software-visible control state of a single DMA descriptor ring. Software reaches it through a simple 32-bit word-addressed register port. Through that port it programs a 64-bit ring base address and a power-of-two ring size. It posts work by moving a head index forward, and it keeps a free 32-bit credits word. Hardware owns the tail index. Each completion pulse from the DMA engine moves the tail one slot forward, wrapping at the ring size.

The block checks every head write against the tail, so software can never lap the hardware. It derives empty and full state from the two indices. It exports the base, both indices and a work-available flag to the DMA engine. Reads are combinational on the read word index and have no side effects. Writes take effect at the next rising clock edge.

Top module: `ring_ptr_regs`

## Requirements
- R1: After reset the base is 0, the size reads 2, head and tail are 0, credits read 0, and the ring reports empty with no work available.
- R2: The 64-bit base output changes only on a write to word 1 (byte offset 0x04). That write takes the written value as bits 63:32, and bits 31:0 come from the most recent write to word 0 (byte offset 0x00) with its bits 2:0 forced to zero. A word-0 write alone leaves the base output unchanged. Words 0 and 1 read back the committed base halves.
- R3: A write to word 0 or word 1, or an accepted write to the size word, returns both head and tail to 0 one cycle later.
- R4: A write to word 2 (byte offset 0x08) is accepted only for a power of two from 2 through 65536. Any other value is ignored: the size readback and both indices are left unchanged.
- R5: A write to word 3 (byte offset 0x0C) sets the head only if the value is below the size and its forward distance from the tail, modulo the size, is at least that of the current head. Otherwise the head is unchanged. Word 3 reads back the head.
- R6: A completion pulse advances the tail by one, modulo the size, when the tail differs from the head. When the tail equals the head, the pulse is ignored. Word 4 (byte offset 0x10) reads back the tail.
- R7: The empty flag is set exactly when head equals tail. The full flag is set exactly when head plus one, modulo the size, equals tail. Work-available is the inverse of empty.
- R8: A write to word 5 (byte offset 0x14) with bit 0 set clears head and tail. With bit 0 clear, the write has no effect. Word 5 always reads 0.
- R9: Writes to word 4 are ignored. Word 6 (byte offset 0x18) holds the credits value written to it. Word 7 (byte offset 0x1C) reads 0.
- R10: When an index clear and a completion pulse arrive in the same cycle, the clear wins and the tail ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_word | input | 3 | Word index of the write (byte offset / 4) |
| wr_data | input | 32 | Write data |
| rd_word | input | 3 | Word index of the read |
| rd_data | output | 32 | Combinational read data |
| cpl_pulse | input | 1 | One-cycle completion from the DMA engine |
| base_addr | output | 64 | Committed ring base address |
| head_idx | output | 16 | Software head index |
| tail_idx | output | 16 | Hardware tail index |
| work_avail | output | 1 | Posted descriptors remain (head differs from tail) |
| ring_empty | output | 1 | Head equals tail |
| ring_full | output | 1 | Head is one slot behind tail |

## Verification
Every write and every completion pulse lands in the registers at the first rising edge after it is driven. The new index, base and flag values are therefore due at the falling edge that follows that edge. The read data is due in the same half cycle as the read word index, because it depends on no further register. The bench drives inputs just after each falling edge and updates its behavioural model at the rising edge from those held inputs. It compares all outputs at the next falling edge, which is exactly one register stage later. The directed checks sample only after their write task has passed that same falling edge.

// File: rtl/ring_regs_pkg.sv
package ring_regs_pkg;

  localparam int unsigned REG_W     = 32;
  localparam int unsigned NUM_WORDS = 8;

  typedef enum logic [2:0] {
    RW_BASE_LO = 3'd0,
    RW_BASE_HI = 3'd1,
    RW_SIZE    = 3'd2,
    RW_HEAD    = 3'd3,
    RW_TAIL    = 3'd4,
    RW_CTRL    = 3'd5,
    RW_CREDIT  = 3'd6,
    RW_SPARE   = 3'd7
  } ring_word_e;

  // Legal ring size: a power of two between 2 and 2**max_log2.
  function automatic logic size_is_legal(input logic [REG_W-1:0] v,
                                         input int unsigned max_log2);
    logic [REG_W:0] limit;
    limit = (REG_W+1)'(1) << max_log2;
    return (v >= REG_W'(2)) && ({1'b0, v} <= limit) &&
           ((v & (v - REG_W'(1))) == '0);
  endfunction

  // Forward distance from from_idx to to_idx on a ring with the given mask.
  function automatic logic [REG_W-1:0] ring_dist(input logic [REG_W-1:0] from_idx,
                                                 input logic [REG_W-1:0] to_idx,
                                                 input logic [REG_W-1:0] mask);
    return (to_idx - from_idx) & mask;
  endfunction

  // Index one slot ahead, wrapped by the mask.
  function automatic logic [REG_W-1:0] ring_next(input logic [REG_W-1:0] idx,
                                                 input logic [REG_W-1:0] mask);
    return (idx + REG_W'(1)) & mask;
  endfunction

endpackage

// File: rtl/ring_wr_decode.sv
module ring_wr_decode
  import ring_regs_pkg::*;
(
  input  logic                 wr_en,
  input  logic [2:0]           wr_word,
  output logic [NUM_WORDS-1:0] wr_strobe
);

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_strobe
    assign wr_strobe[g] = wr_en && (wr_word == 3'(g));
  end

endmodule

// File: rtl/ring_base_reg.sv
module ring_base_reg
  import ring_regs_pkg::*;
#(
  parameter int unsigned ALIGN_BITS = 3,
  localparam int unsigned ADDR_W = 2 * REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [REG_W-1:0]  wdata,
  output logic [ADDR_W-1:0] base_addr
);

  logic [REG_W-1:0] lo_shadow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_shadow <= '0;
      base_addr <= '0;
    end else begin
      if (lo_we) lo_shadow <= {wdata[REG_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      if (hi_we) base_addr <= {wdata, lo_shadow};
    end
  end

endmodule

// File: rtl/ring_index_ctl.sv
module ring_index_ctl
  import ring_regs_pkg::*;
#(
  parameter int unsigned MAX_LOG2 = 16,
  localparam int unsigned IDX_W  = MAX_LOG2,
  localparam int unsigned SIZE_W = MAX_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              size_we,
  input  logic              head_we,
  input  logic              ctrl_we,
  input  logic              base_we,
  input  logic [REG_W-1:0]  wdata,
  input  logic              cpl_pulse,
  output logic [SIZE_W-1:0] size_q,
  output logic [IDX_W-1:0]  head_idx,
  output logic [IDX_W-1:0]  tail_idx,
  output logic [IDX_W-1:0]  idx_mask,
  output logic              size_reject,
  output logic              head_accept,
  output logic              head_reject,
  output logic              idx_clear,
  output logic              tail_step
);

  logic [REG_W-1:0] mask_w, head_w, tail_w;
  logic             size_ok, head_fits, head_order_ok;

  assign mask_w   = REG_W'(size_q) - REG_W'(1);
  assign head_w   = REG_W'(head_idx);
  assign tail_w   = REG_W'(tail_idx);
  assign idx_mask = IDX_W'(mask_w);

  always_comb begin
    size_ok       = size_we && size_is_legal(wdata, MAX_LOG2);
    size_reject   = size_we && !size_ok;
    head_fits     = wdata < REG_W'(size_q);
    head_order_ok = ring_dist(tail_w, wdata, mask_w) >= ring_dist(tail_w, head_w, mask_w);
    head_accept   = head_we && head_fits && head_order_ok;
    head_reject   = head_we && !head_accept;
    idx_clear     = base_we || size_ok || (ctrl_we && wdata[0]);
    tail_step     = cpl_pulse && (head_idx != tail_idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q   <= SIZE_W'(2);
      head_idx <= '0;
      tail_idx <= '0;
    end else begin
      if (size_ok) size_q <= SIZE_W'(wdata);
      if (idx_clear) begin
        head_idx <= '0;
        tail_idx <= '0;
      end else begin
        if (head_accept) head_idx <= IDX_W'(wdata);
        if (tail_step)   tail_idx <= IDX_W'(ring_next(tail_w, mask_w));
      end
    end
  end

endmodule

// File: rtl/ring_read_mux.sv
module ring_read_mux
  import ring_regs_pkg::*;
#(
  parameter int unsigned MAX_LOG2 = 16,
  localparam int unsigned IDX_W  = MAX_LOG2,
  localparam int unsigned SIZE_W = MAX_LOG2 + 1
) (
  input  logic [2:0]         rd_word,
  input  logic [2*REG_W-1:0] base_addr,
  input  logic [SIZE_W-1:0]  size_q,
  input  logic [IDX_W-1:0]   head_idx,
  input  logic [IDX_W-1:0]   tail_idx,
  input  logic [REG_W-1:0]   credits_q,
  output logic [REG_W-1:0]   rd_data
);

  always_comb begin
    case (ring_word_e'(rd_word))
      RW_BASE_LO: rd_data = base_addr[REG_W-1:0];
      RW_BASE_HI: rd_data = base_addr[2*REG_W-1:REG_W];
      RW_SIZE:    rd_data = REG_W'(size_q);
      RW_HEAD:    rd_data = REG_W'(head_idx);
      RW_TAIL:    rd_data = REG_W'(tail_idx);
      RW_CREDIT:  rd_data = credits_q;
      default:    rd_data = '0;
    endcase
  end

endmodule

// File: rtl/ring_ptr_regs.sv
module ring_ptr_regs
  import ring_regs_pkg::*;
#(
  parameter int unsigned MAX_LOG2 = 16,
  localparam int unsigned IDX_W  = MAX_LOG2,
  localparam int unsigned SIZE_W = MAX_LOG2 + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_word,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [2:0]         rd_word,
  output logic [REG_W-1:0]   rd_data,
  input  logic               cpl_pulse,
  output logic [2*REG_W-1:0] base_addr,
  output logic [IDX_W-1:0]   head_idx,
  output logic [IDX_W-1:0]   tail_idx,
  output logic               work_avail,
  output logic               ring_empty,
  output logic               ring_full
);

  logic [NUM_WORDS-1:0] wr_strobe;
  logic                 base_lo_we, base_hi_we;
  logic [SIZE_W-1:0]    size_q;
  logic [IDX_W-1:0]     idx_mask;
  logic                 size_reject, head_accept, head_reject, idx_clear, tail_step;
  logic [REG_W-1:0]     credits_q;
  logic                 unused_strobes;

  ring_wr_decode u_dec (
    .wr_en     (wr_en),
    .wr_word   (wr_word),
    .wr_strobe (wr_strobe)
  );

  assign base_lo_we     = wr_strobe[RW_BASE_LO];
  assign base_hi_we     = wr_strobe[RW_BASE_HI];
  assign unused_strobes = wr_strobe[RW_TAIL] | wr_strobe[RW_SPARE];

  ring_base_reg u_base (
    .clk       (clk),
    .rst_n     (rst_n),
    .lo_we     (base_lo_we),
    .hi_we     (base_hi_we),
    .wdata     (wr_data),
    .base_addr (base_addr)
  );

  ring_index_ctl #(.MAX_LOG2(MAX_LOG2)) u_idx (
    .clk         (clk),
    .rst_n       (rst_n),
    .size_we     (wr_strobe[RW_SIZE]),
    .head_we     (wr_strobe[RW_HEAD]),
    .ctrl_we     (wr_strobe[RW_CTRL]),
    .base_we     (base_lo_we | base_hi_we),
    .wdata       (wr_data),
    .cpl_pulse   (cpl_pulse),
    .size_q      (size_q),
    .head_idx    (head_idx),
    .tail_idx    (tail_idx),
    .idx_mask    (idx_mask),
    .size_reject (size_reject),
    .head_accept (head_accept),
    .head_reject (head_reject),
    .idx_clear   (idx_clear),
    .tail_step   (tail_step)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                    credits_q <= '0;
    else if (wr_strobe[RW_CREDIT]) credits_q <= wr_data;
  end

  assign ring_empty = (head_idx == tail_idx);
  assign ring_full  = (IDX_W'(ring_next(REG_W'(head_idx), REG_W'(idx_mask))) == tail_idx);
  assign work_avail = !ring_empty;

  ring_read_mux #(.MAX_LOG2(MAX_LOG2)) u_rd (
    .rd_word   (rd_word),
    .base_addr (base_addr),
    .size_q    (size_q),
    .head_idx  (head_idx),
    .tail_idx  (tail_idx),
    .credits_q (credits_q),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/ring_ptr_regs_chk.sv
module ring_ptr_regs_chk #(
  parameter int unsigned MAX_LOG2 = 16,
  localparam int unsigned IDX_W  = MAX_LOG2,
  localparam int unsigned SIZE_W = MAX_LOG2 + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpl_pulse,
  input logic              base_lo_we,
  input logic              size_reject,
  input logic              head_reject,
  input logic              idx_clear,
  input logic              tail_step,
  input logic              ring_empty,
  input logic              ring_full,
  input logic [63:0]       base_addr,
  input logic [SIZE_W-1:0] size_q,
  input logic [IDX_W-1:0]  head_idx,
  input logic [IDX_W-1:0]  tail_idx,
  input logic [IDX_W-1:0]  idx_mask
);

  // R2
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_lo_we |=> $stable(base_addr));

  // R2
  base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_addr[2:0] == 3'b000);

  // R3
  idx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_clear |=> (head_idx == '0 && tail_idx == '0));

  // R4
  size_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_reject |=> $stable(size_q));

  // R5
  head_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (head_reject && !idx_clear) |=> $stable(head_idx));

  // R6
  tail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_step && !idx_clear) |=>
      tail_idx == IDX_W'(($past(tail_idx) + IDX_W'(1)) & $past(idx_mask)));

  // R6
  tail_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpl_pulse && !idx_clear) |=> $stable(tail_idx));

  // R7
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_empty && !idx_clear) |=> $stable(tail_idx));

  // R7
  full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ring_full |-> !ring_empty);

  // R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_clear && cpl_pulse) |=> tail_idx == '0);

endmodule

bind ring_ptr_regs ring_ptr_regs_chk #(.MAX_LOG2(MAX_LOG2)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpl_pulse   (cpl_pulse),
  .base_lo_we  (base_lo_we),
  .size_reject (size_reject),
  .head_reject (head_reject),
  .idx_clear   (idx_clear),
  .tail_step   (tail_step),
  .ring_empty  (ring_empty),
  .ring_full   (ring_full),
  .base_addr   (base_addr),
  .size_q      (size_q),
  .head_idx    (head_idx),
  .tail_idx    (tail_idx),
  .idx_mask    (idx_mask)
);

// File: tb/ring_ptr_regs_tb.sv
`timescale 1ns/1ps
module ring_ptr_regs_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_word = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_word = '0;
  logic [31:0] rd_data;
  logic        cpl_pulse = 1'b0;
  logic [63:0] base_addr;
  logic [15:0] head_idx, tail_idx;
  logic        work_avail, ring_empty, ring_full;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ring_ptr_regs u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data),
    .rd_word(rd_word), .rd_data(rd_data), .cpl_pulse(cpl_pulse),
    .base_addr(base_addr), .head_idx(head_idx), .tail_idx(tail_idx),
    .work_avail(work_avail), .ring_empty(ring_empty), .ring_full(ring_full)
  );

  // Behavioural reference state
  logic [63:0]  m_base, m_lo;
  int unsigned  m_size, m_head, m_tail;
  logic [31:0]  m_credits;

  function automatic bit legal_size(input logic [31:0] v);
    for (int k = 1; k <= 16; k++) if (v == (32'd1 << k)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int unsigned fwd(input int unsigned a, input int unsigned b);
    return (a + m_size - b) % m_size;
  endfunction

  function automatic logic [31:0] exp_read(input logic [2:0] w);
    case (w)
      3'd0: return m_base[31:0];
      3'd1: return m_base[63:32];
      3'd2: return m_size;
      3'd3: return m_head;
      3'd4: return m_tail;
      3'd6: return m_credits;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_base = '0; m_lo = '0; m_size = 2; m_head = 0; m_tail = 0; m_credits = '0;
    end else begin
      bit clr;
      int unsigned nh, nt;
      clr = 1'b0; nh = m_head; nt = m_tail;
      if (wr_en) begin
        case (wr_word)
          3'd0: begin m_lo = {32'd0, wr_data & 32'hFFFF_FFF8}; clr = 1'b1; end
          3'd1: begin m_base = {wr_data, m_lo[31:0]}; clr = 1'b1; end
          3'd2: if (legal_size(wr_data)) begin m_size = wr_data; clr = 1'b1; end
          3'd3: if (wr_data < m_size && fwd(wr_data, m_tail) >= fwd(m_head, m_tail)) nh = wr_data;
          3'd5: if (wr_data[0]) clr = 1'b1;
          3'd6: m_credits = wr_data;
          default: ;
        endcase
      end
      if (cpl_pulse && m_tail != m_head) nt = (m_tail + 1) % m_size;
      if (clr) begin m_head = 0; m_tail = 0; end
      else begin m_head = nh; m_tail = nt; end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison, one register stage after each edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R5 head", 64'(head_idx), 64'(m_head));
      check("R6 tail", 64'(tail_idx), 64'(m_tail));
      check("R2 base", base_addr, m_base);
      check("R7 flags", {61'd0, work_avail, ring_empty, ring_full},
            {61'd0, m_head != m_tail, m_head == m_tail, ((m_head + 1) % m_size) == m_tail});
      check("R9 read", 64'(rd_data), 64'(exp_read(rd_word)));
    end
  end

  task automatic wr(input logic [2:0] w, input logic [31:0] d, input bit cpl = 1'b0);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_word = w; wr_data = d; cpl_pulse = cpl;
    @(negedge clk); #1;
    wr_en = 1'b0; cpl_pulse = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1; cpl_pulse = 1'b1;
      @(negedge clk); #1; cpl_pulse = 1'b0;
    end
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] w, input logic [31:0] exp);
    rd_word = w; #0.2;
    check(tag, 64'(rd_data), 64'(exp));
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check("R1 head", 64'(head_idx), 0);
    check("R1 tail", 64'(tail_idx), 0);
    check("R1 base", base_addr, 0);
    check("R1 empty", {62'd0, ring_empty, work_avail}, 64'd2);
    rd_chk("R1 size", 3'd2, 32'd2);
    rd_chk("R1 credits", 3'd6, 32'd0);

    wr(3'd2, 32'd8);
    rd_chk("R4 size 8", 3'd2, 32'd8);
    wr(3'd3, 32'd5);
    check("R5 head 5", 64'(head_idx), 5);
    check("R7 work", 64'(work_avail), 1);
    pulse(2);
    check("R6 tail 2", 64'(tail_idx), 2);
    wr(3'd3, 32'd1);
    check("R5 head wraps to 1", 64'(head_idx), 1);
    check("R7 full", 64'(ring_full), 1);
    wr(3'd3, 32'd3);
    check("R5 pass tail refused", 64'(head_idx), 1);
    wr(3'd3, 32'd9);
    check("R5 beyond size refused", 64'(head_idx), 1);
    pulse(7);
    check("R6 tail caught up", 64'(tail_idx), 1);
    pulse(1);
    check("R6 pulse on empty ignored", 64'(tail_idx), 1);
    check("R7 empty", 64'(ring_empty), 1);

    wr(3'd3, 32'd4);
    wr(3'd2, 32'd6);
    wr(3'd2, 32'd0);
    wr(3'd2, 32'd1);
    wr(3'd2, 32'h0002_0000);
    rd_chk("R4 illegal sizes kept", 3'd2, 32'd8);
    check("R4 indices kept", {32'(head_idx), 32'(tail_idx)}, {32'd4, 32'd1});
    wr(3'd2, 32'h0001_0000);
    rd_chk("R4 max size", 3'd2, 32'h0001_0000);
    check("R3 size clears", {32'(head_idx), 32'(tail_idx)}, 64'd0);

    wr(3'd3, 32'd100);
    wr(3'd0, 32'h1234_567F);
    check("R2 low alone holds base", base_addr, 64'd0);
    check("R3 base low clears", 64'(head_idx), 0);
    rd_chk("R2 base low readback", 3'd0, 32'd0);
    wr(3'd1, 32'h0000_ABCD);
    check("R2 base commit", base_addr, 64'h0000_ABCD_1234_5678);

    wr(3'd3, 32'd10);
    wr(3'd5, 32'd2);
    check("R8 bit0 clear no effect", 64'(head_idx), 10);
    wr(3'd5, 32'd1);
    check("R8 ring reset", {32'(head_idx), 32'(tail_idx)}, 64'd0);
    rd_chk("R8 ctrl reads zero", 3'd5, 32'd0);

    wr(3'd3, 32'd3);
    wr(3'd4, 32'd7);
    check("R9 tail write ignored", 64'(tail_idx), 0);
    wr(3'd6, 32'hCAFE_F00D);
    rd_chk("R9 credits", 3'd6, 32'hCAFE_F00D);
    rd_chk("R9 reserved", 3'd7, 32'd0);
    pulse(1);
    wr(3'd5, 32'd1, 1'b1);
    check("R10 clear beats completion", {32'(head_idx), 32'(tail_idx)}, 64'd0);

    wr(3'd2, 32'd4);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      int sel;
      @(negedge clk); #1;
      r = $urandom;
      sel = $urandom_range(0, 11);
      wr_en = (r[3:0] < 4'd7);
      cpl_pulse = r[4] | r[5];
      rd_word = r[10:8];
      case (sel)
        0, 1, 2, 3, 4, 5: begin wr_word = 3'd3; wr_data = $urandom_range(0, 2 * m_size); end
        6: begin
          wr_word = 3'd2;
          case (r[13:11])
            3'd0: wr_data = 32'd2;  3'd1: wr_data = 32'd4;  3'd2: wr_data = 32'd8;
            3'd3: wr_data = 32'd16; 3'd4: wr_data = 32'd3;  3'd5: wr_data = 32'd0;
            default: wr_data = 32'd12;
          endcase
        end
        7: begin wr_word = 3'd5; wr_data = $urandom_range(0, 3); end
        8: begin wr_word = 3'd0; wr_data = $urandom; end
        9: begin wr_word = 3'd1; wr_data = $urandom; end
        default: begin wr_word = 3'($urandom_range(4, 7)); wr_data = $urandom; end
      endcase
    end
    @(negedge clk); #1;
    wr_en = 1'b0; cpl_pulse = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule